// File: doc/BRIEF.md
# Masked Interrupt Status Controller

This block gathers interrupt requests from peripherals into a sticky status register and gates them with a mask register. It raises one level interrupt toward the CPU while any enabled status bit is set. A peripheral sets its status bit by holding its request line high at a clock edge. By convention, bit 3 carries the request from the DMA controller's interrupt logic.

Software reads both registers on a simple register bus. It acknowledges requests by writing the status register. A written 0 clears the bit, and a written 1 leaves the bit as it is. Writing the mask register replaces the enabled set.

The interrupt output comes from a two-state machine. In state IRQ_IDLE the output is low. In state IRQ_RAISED the output is high. The transition IDLE→RAISED happens when the next-cycle status AND mask is nonzero. The transition RAISED→IDLE happens when it becomes zero. The machine therefore follows both registers with no extra delay. Unmasking a bit that is already pending raises the interrupt on the same edge that stores the new mask.

Top module: `masked_irq_ctl`

## Requirements
- R1: After reset, both registers read zero and `irq_out` is low.
- R2: A bit of `hw_req` that is high at a rising clock edge sets the matching status bit. The bit stays set until software acknowledges it.
- R3: A write to the status register (offset 0x70) stores old status AND written data, separately in each enabled byte lane. Lane 0 covers bits 7:0 and lane 1 covers bits 15:8. A disabled lane keeps its bits.
- R4: A write to the mask register (offset 0x74) replaces the mask bits of each enabled byte lane. A disabled lane keeps its bits, and the mask never changes without such a write.
- R5: When a request and an acknowledge reach the same status bit on the same edge, the bit ends set.
- R6: `irq_out` is high exactly when status AND mask is nonzero. It updates on the same edge that changes either register.
- R7: Reads are combinational and have no side effects. Offset 0x70 returns status in bits 15:0, and offset 0x74 returns the mask there. Bits 31:16 read zero, and any other offset reads zero.
- R8: Write data bits 31:16 and byte enables 3:2 have no effect on either register. A write to an unmapped offset changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_be | input | 4 | Byte-lane enables for the write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| hw_req | input | 16 | Peripheral request lines, sampled each edge |
| irq_out | output | 1 | Level interrupt to the CPU |

## Verification
A peripheral request and a software acknowledge can land on the same status bit in the same cycle. The bench provokes this in directed cases, with an all-zero acknowledge while a request is held on bit 3. The random phase provokes it far more often by mixing random requests with random status writes. The bench judges the outcome by reading the status back and comparing it with a bench model in which the request's set is applied after the acknowledge's AND. It also checks that `irq_out` follows the modelled status AND mask on the same edge.

// File: rtl/masked_irq_ctl_pkg.sv
package masked_irq_ctl_pkg;
    typedef enum logic {
        IRQ_IDLE   = 1'b0,
        IRQ_RAISED = 1'b1
    } irq_state_e;

    localparam logic [7:0] STAT_OFS_DEF = 8'h70;
    localparam logic [7:0] MASK_OFS_DEF = 8'h74;
endpackage

// File: rtl/masked_irq_ctl_decode.sv
module masked_irq_ctl_decode #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int REG_W  = 16,
    parameter logic [ADDR_W-1:0] STAT_OFS = 8'h70,
    parameter logic [ADDR_W-1:0] MASK_OFS = 8'h74
) (
    input  logic [ADDR_W-1:0]   addr,
    input  logic                wr,
    input  logic [DATA_W/8-1:0] be,
    input  logic [REG_W-1:0]    stat_q,
    input  logic [REG_W-1:0]    mask_q,
    output logic                stat_we,
    output logic                mask_we,
    output logic [REG_W-1:0]    lane_bits,
    output logic [DATA_W-1:0]   rdata
);
    localparam int LANES = REG_W / 8;

    assign stat_we = wr && (addr == STAT_OFS);
    assign mask_we = wr && (addr == MASK_OFS);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_bits[g*8 +: 8] = {8{be[g]}};
    end

    always_comb begin
        rdata = '0;
        if (addr == STAT_OFS)      rdata[REG_W-1:0] = stat_q;
        else if (addr == MASK_OFS) rdata[REG_W-1:0] = mask_q;
    end
endmodule

// File: rtl/masked_irq_ctl_regs.sv
module masked_irq_ctl_regs #(
    parameter int REG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stat_we,
    input  logic             mask_we,
    input  logic [REG_W-1:0] lane_bits,
    input  logic [REG_W-1:0] wdata,
    input  logic [REG_W-1:0] hw_req,
    output logic [REG_W-1:0] stat_d,
    output logic [REG_W-1:0] mask_d,
    output logic [REG_W-1:0] stat_q,
    output logic [REG_W-1:0] mask_q
);
    logic [REG_W-1:0] ack_keep;

    // A disabled lane acts as all-ones, which keeps the bits of that lane.
    assign ack_keep = wdata | ~lane_bits;

    always_comb begin
        stat_d = stat_we ? (stat_q & ack_keep) : stat_q;
        stat_d = stat_d | hw_req;        // set wins over clear
        mask_d = mask_we ? ((mask_q & ~lane_bits) | (wdata & lane_bits)) : mask_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
            mask_q <= '0;
        end else begin
            stat_q <= stat_d;
            mask_q <= mask_d;
        end
    end
endmodule

// File: rtl/masked_irq_ctl_irq_fsm.sv
module masked_irq_ctl_irq_fsm
    import masked_irq_ctl_pkg::*;
#(
    parameter int REG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] stat_d,
    input  logic [REG_W-1:0] mask_d,
    output logic             irq_out
);
    irq_state_e state_q, state_d;
    logic       pend_d;

    assign pend_d = |(stat_d & mask_d);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE:   if (pend_d)  state_d = IRQ_RAISED;
            IRQ_RAISED: if (!pend_d) state_d = IRQ_IDLE;
            default:    state_d = IRQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= IRQ_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            IRQ_RAISED: irq_out = 1'b1;
            default:    irq_out = 1'b0;
        endcase
    end
endmodule

// File: rtl/masked_irq_ctl.sv
module masked_irq_ctl
    import masked_irq_ctl_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int REG_W  = 16,
    parameter logic [ADDR_W-1:0] STAT_OFS = STAT_OFS_DEF,
    parameter logic [ADDR_W-1:0] MASK_OFS = MASK_OFS_DEF
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr,
    input  logic [DATA_W/8-1:0] bus_be,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic [REG_W-1:0]    hw_req,
    output logic                irq_out
);
    logic             stat_we, mask_we;
    logic [REG_W-1:0] lane_bits, stat_d, mask_d, stat_q, mask_q;

    masked_irq_ctl_decode #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_W(REG_W),
        .STAT_OFS(STAT_OFS), .MASK_OFS(MASK_OFS)
    ) u_decode (
        .addr(bus_addr), .wr(bus_wr), .be(bus_be),
        .stat_q(stat_q), .mask_q(mask_q),
        .stat_we(stat_we), .mask_we(mask_we),
        .lane_bits(lane_bits), .rdata(bus_rdata)
    );

    masked_irq_ctl_regs #(.REG_W(REG_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .stat_we(stat_we), .mask_we(mask_we),
        .lane_bits(lane_bits), .wdata(bus_wdata[REG_W-1:0]),
        .hw_req(hw_req),
        .stat_d(stat_d), .mask_d(mask_d),
        .stat_q(stat_q), .mask_q(mask_q)
    );

    masked_irq_ctl_irq_fsm #(.REG_W(REG_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .stat_d(stat_d), .mask_d(mask_d),
        .irq_out(irq_out)
    );
endmodule

// File: rtl/masked_irq_ctl_chk.sv
module masked_irq_ctl_chk #(
    parameter int ADDR_W = 8,
    parameter int REG_W  = 16,
    parameter logic [ADDR_W-1:0] MASK_OFS = 8'h74
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [REG_W-1:0]  hw_req,
    input logic [REG_W-1:0]  stat_q,
    input logic [REG_W-1:0]  mask_q,
    input logic              irq_out
);
    // R2 and R5: a request always leaves its bit set, whatever the acknowledge did
    a_r2_req_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (|hw_req) |=> ((stat_q & $past(hw_req)) == $past(hw_req)));

    // R2: status bits only rise because of a request
    a_r2_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(hw_req)) == '0));

    // R4: the mask holds unless its register is written
    a_r4_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == MASK_OFS) |=> $stable(mask_q));

    // R6: the state machine output matches the stored registers
    a_r6_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out == (|(stat_q & mask_q)));

    // R3: with no write at all, status bits never fall
    a_r3_no_clear_without_write: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> ((~stat_q & $past(stat_q)) == '0));
endmodule

bind masked_irq_ctl masked_irq_ctl_chk #(
    .ADDR_W(ADDR_W), .REG_W(REG_W), .MASK_OFS(MASK_OFS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .hw_req(hw_req), .stat_q(stat_q), .mask_q(mask_q), .irq_out(irq_out)
);

// File: tb/masked_irq_ctl_bench.sv
module masked_irq_ctl_bench;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] STAT = 8'h70;
    localparam logic [7:0] MASK = 8'h74;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] hw_req = '0;
    logic        irq_out;

    logic [15:0] m_stat = '0, m_mask = '0;
    int ntests = 0, nfails = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    masked_irq_ctl u_masked_irq_ctl (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .hw_req(hw_req), .irq_out(irq_out)
    );

    function automatic logic [15:0] lanes(input logic [3:0] be);
        return {{8{be[1]}}, {8{be[0]}}};
    endfunction

    function automatic logic [15:0] next_stat(input logic [15:0] s, input logic wr,
        input logic [7:0] a, input logic [31:0] d, input logic [3:0] be, input logic [15:0] rq);
        logic [15:0] r = s;
        if (wr && a == STAT) r = s & (d[15:0] | ~lanes(be));
        return r | rq;
    endfunction

    function automatic logic [15:0] next_mask(input logic [15:0] m, input logic wr,
        input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
        if (wr && a == MASK) return (m & ~lanes(be)) | (d[15:0] & lanes(be));
        return m;
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        ntests++;
        if (got !== exp) begin
            nfails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // One clock: drive at negedge, model at posedge, return at next negedge
    task automatic cycle(input logic wr, input logic [7:0] a, input logic [31:0] d,
                         input logic [3:0] be, input logic [15:0] rq);
        bus_wr = wr; bus_addr = a; bus_wdata = d; bus_be = be; hw_req = rq;
        @(posedge clk);
        m_stat = next_stat(m_stat, wr, a, d, be, rq);
        m_mask = next_mask(m_mask, wr, a, d, be);
        @(negedge clk);
        bus_wr = 1'b0; hw_req = '0;
        check("R6 irq level", {31'b0, irq_out}, {31'b0, |(m_stat & m_mask)});
    endtask

    task automatic read_check(input string req);
        bus_wr = 1'b0;
        bus_addr = STAT; #1; check({req, " status"}, bus_rdata, {16'b0, m_stat});
        bus_addr = MASK; #1; check({req, " mask"},   bus_rdata, {16'b0, m_mask});
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            ntests++; nfails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", ntests, nfails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        read_check("R1");
        check("R1 irq low", {31'b0, irq_out}, 32'b0);

        // R2 request latches and sticks; mask still zero so no irq
        cycle(0, 8'h00, 0, 0, 16'h0008);
        cycle(0, 8'h00, 0, 0, 16'h0000);
        read_check("R2");
        check("R6 masked no irq", {31'b0, irq_out}, 32'b0);

        // R6 unmask a pending bit raises irq on that edge
        cycle(1, MASK, 32'h0000_0008, 4'h3, 0);
        check("R6 unmask immediate", {31'b0, irq_out}, 32'b1);
        read_check("R4");

        // R5 ack all-zero while request held on bit 3
        cycle(1, STAT, 32'h0, 4'hF, 16'h0008);
        read_check("R5");
        check("R5 bit3 kept", {31'b0, m_stat[3]}, 32'b1);

        // R3 ack clears, disabled lane kept
        cycle(0, 8'h00, 0, 0, 16'h0901);
        cycle(1, STAT, 32'h0, 4'h2, 0);     // only high lane: clears bit 8,11
        read_check("R3 lane1");
        check("R3 low lane kept", {16'b0, m_stat}, 32'h0009);
        cycle(1, STAT, 32'hFFFF_FFF7, 4'h1, 0);
        read_check("R3 ack bit3");
        check("R6 irq dropped", {31'b0, irq_out}, 32'b0);

        // R8 upper data and lanes 2,3 ignored, unmapped write ignored
        cycle(1, MASK, 32'hFFFF_0000, 4'hC, 0);
        read_check("R8 upper");
        cycle(1, 8'h78, 32'h0000_FFFF, 4'hF, 0);
        read_check("R8 unmapped");

        // R7 unmapped read zero, reads repeatable
        bus_addr = 8'h7C; #1; check("R7 unmapped read", bus_rdata, 32'h0);
        bus_addr = 8'h00; #1; check("R7 unmapped read", bus_rdata, 32'h0);
        read_check("R7 repeat");
        @(negedge clk);

        // Random phase mixing requests, acknowledges and mask writes
        for (int i = 0; i < 400; i++) begin
            logic [7:0] a;
            logic [15:0] rq;
            case ($urandom % 4)
                0: a = STAT;
                1: a = MASK;
                2: a = STAT;
                default: a = 8'($urandom);
            endcase
            rq = (($urandom % 3) == 0) ? 16'($urandom) & 16'($urandom) : 16'h0;
            cycle(1'($urandom), a, $urandom, 4'($urandom), rq);
            read_check("R2 R3 R4 R5 random");
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", ntests, nfails);
        $finish;
    end
endmodule